// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a small two-level logic array that a serial bitstream can reconfigure. Each input reaches a programmable AND plane as two literals: its true value and its complement. Every product term is the AND of the literals connected to it. A second programmable plane ORs any chosen set of product terms into each output. Any set of Boolean functions that fits the array's product-term budget can therefore be placed on the outputs without changing the silicon.

The configuration is held in one shift chain and is loaded one bit per system clock while the load enable is high. The array stays idle during a load, so no partial configuration ever reaches the pins. Each output also has a configuration bit that passes it through a flip-flop, which lets the array build state machines and other sequential circuits.

A build-time parameter can fix the OR plane instead. In that mode each output ORs its own group of adjacent product terms, and the chain carries no OR field. The default geometry is 4 inputs, 8 product terms and 4 outputs.

Top module: `sop_logic_array`

## Requirements
- R1: Each output equals the OR of the product terms connected to it. A product term is the AND of the literals connected to it.
- R2: Literal 2*i of a product term is input i in true form, and literal 2*i+1 is input i complemented. The connection bit for product p, literal l sits at position p*2*N_IN+l of the AND field.
- R3: A product term with no connected literals evaluates to 0, so an all-zero configuration drives every output low for every input.
- R4: A product term that connects both the true and the complemented literal of the same input evaluates to 0 for every input.
- R5: In programmable mode, bit o*N_PT+p of the OR field connects product p to output o.
- R6: The chain shifts one bit per rising clock edge while cfg_en_i is high, most significant bit first. Load order is the AND field, then the OR field, then the register field, each field MSB first. While cfg_en_i is low the configuration does not change.
- R7: While cfg_en_i is high, every output reads 0, and every rising edge clears the output flip-flops. A registered output therefore reads 0 after a load until its first capture edge.
- R8: When bit o of the register field is set, output o shows the sum-of-products value sampled at the previous rising edge. When that bit is clear, output o is combinational.
- R9: With FIXED_OR set, output o ORs product terms o*G to o*G+G-1, where G = N_PT/N_OUT, and the chain has no OR field.
- R10: The active-low asynchronous reset clears the configuration and the output flip-flops, so all outputs read 0 during reset and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; shifts the chain and clocks the output flip-flops |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Configuration load enable; the array is idle while high |
| cfg_bit_i | input | 1 | Serial configuration data, MSB first |
| data_i | input | N_IN | Logic inputs |
| q_o | output | N_OUT | Logic outputs |

## Verification
The corners that are hardest to reach from the pins are product terms that read 0 while still connected to an output. One kind is a term with no literals; the other is a term holding both polarities of one input. They can only be seen if some other term on the same output is known to be able to drive it high. The bench loads a hand-built configuration that places such terms next to live terms, sweeps all input combinations, and compares every output with a model computed from the loaded bits. It then repeats the sweep with pseudo-random sparse configurations. For registered outputs, each sweep step checks the value both before and after the capture edge.

// File: rtl/sop_pkg.sv
`timescale 1ns/1ps
package sop_pkg;
  function automatic int cfg_len(int n_in, int n_pt, int n_out, bit fixed_or);
    return 2 * n_in * n_pt + (fixed_or ? 0 : n_pt * n_out) + n_out;
  endfunction
endpackage

// File: rtl/sop_cfg_chain.sv
`timescale 1ns/1ps
module sop_cfg_chain #(
  parameter int LEN = 100
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           bit_i,
  output logic [LEN-1:0] sr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_o <= '0;
    else if (en_i) sr_o <= {sr_o[LEN-2:0], bit_i};
  end
endmodule

// File: rtl/sop_and_plane.sv
`timescale 1ns/1ps
module sop_and_plane #(
  parameter int N_IN = 4,
  parameter int N_PT = 8,
  localparam int LW  = 2 * N_IN
) (
  input  logic [N_IN-1:0]      data_i,
  input  logic [LW*N_PT-1:0]   conn_i,
  output logic [N_PT-1:0]      pt_o
);
  logic [LW-1:0] lit;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = data_i[i];
    assign lit[2*i+1] = ~data_i[i];
  end

  for (genvar p = 0; p < N_PT; p++) begin : g_pt
    logic [LW-1:0] c;
    assign c       = conn_i[p*LW +: LW];
    // empty term reads 0, not 1
    assign pt_o[p] = (|c) & (&(~c | lit));
  end
endmodule

// File: rtl/sop_or_plane.sv
`timescale 1ns/1ps
module sop_or_plane #(
  parameter int N_PT  = 8,
  parameter int N_OUT = 4
) (
  input  logic [N_PT-1:0]       pt_i,
  input  logic [N_PT*N_OUT-1:0] conn_i,
  output logic [N_OUT-1:0]      sum_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    assign sum_o[o] = |(pt_i & conn_i[o*N_PT +: N_PT]);
  end
endmodule

// File: rtl/sop_out_stage.sv
`timescale 1ns/1ps
module sop_out_stage #(
  parameter int N_OUT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_i,
  input  logic [N_OUT-1:0] reg_en_i,
  input  logic [N_OUT-1:0] sum_i,
  output logic [N_OUT-1:0] q_o
);
  logic [N_OUT-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ff_q <= '0;
    else if (idle_i) ff_q <= '0;
    else             ff_q <= sum_i;
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_q
    assign q_o[o] = idle_i ? 1'b0 : (reg_en_i[o] ? ff_q[o] : sum_i[o]);
  end
endmodule

// File: rtl/sop_logic_array.sv
`timescale 1ns/1ps
module sop_logic_array #(
  parameter int N_IN     = 4,
  parameter int N_PT     = 8,
  parameter int N_OUT    = 4,
  parameter bit FIXED_OR = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_bit_i,
  input  logic [N_IN-1:0]  data_i,
  output logic [N_OUT-1:0] q_o
);
  localparam int AND_W = 2 * N_IN * N_PT;
  localparam int OR_W  = N_PT * N_OUT;
  localparam int GRP   = N_PT / N_OUT;
  localparam int LEN   = sop_pkg::cfg_len(N_IN, N_PT, N_OUT, FIXED_OR);

  logic [LEN-1:0]   sr;
  logic [AND_W-1:0] and_conn;
  logic [OR_W-1:0]  or_conn;
  logic [N_OUT-1:0] reg_en;
  logic [N_PT-1:0]  pt;
  logic [N_OUT-1:0] sum;

  sop_cfg_chain #(.LEN(LEN)) u_chain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cfg_en_i),
    .bit_i (cfg_bit_i),
    .sr_o  (sr)
  );

  assign and_conn = sr[LEN-1 -: AND_W];
  assign reg_en   = sr[N_OUT-1:0];

  if (FIXED_OR) begin : g_fixed_or
    for (genvar o = 0; o < N_OUT; o++) begin : g_o
      for (genvar p = 0; p < N_PT; p++) begin : g_p
        assign or_conn[o*N_PT+p] = ((p / GRP) == o);
      end
    end
  end else begin : g_prog_or
    assign or_conn = sr[N_OUT +: OR_W];
  end

  sop_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .data_i(data_i),
    .conn_i(and_conn),
    .pt_o  (pt)
  );

  sop_or_plane #(.N_PT(N_PT), .N_OUT(N_OUT)) u_or (
    .pt_i  (pt),
    .conn_i(or_conn),
    .sum_o (sum)
  );

  sop_out_stage #(.N_OUT(N_OUT)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idle_i  (cfg_en_i),
    .reg_en_i(reg_en),
    .sum_i   (sum),
    .q_o     (q_o)
  );
endmodule

// File: rtl/sop_array_chk.sv
`timescale 1ns/1ps
module sop_array_chk #(
  parameter int N_IN  = 4,
  parameter int N_PT  = 8,
  parameter int N_OUT = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cfg_en_i,
  input logic [N_OUT-1:0]       q_o,
  input logic [N_OUT-1:0]       reg_en_i,
  input logic [N_OUT-1:0]       sum_i,
  input logic [2*N_IN*N_PT-1:0] and_conn_i
);
  // R7
  idle_out_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |-> (q_o == '0));

  // R7
  load_clears_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> ((q_o & reg_en_i) == '0));

  // R8
  reg_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> (cfg_en_i || ((q_o & reg_en_i) == ($past(sum_i) & reg_en_i))));

  // R3
  empty_array_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (and_conn_i == '0) |-> (sum_i == '0));

  // R6
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_en_i |=> $stable(and_conn_i) && $stable(reg_en_i));
endmodule

bind sop_logic_array sop_array_chk #(.N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_en_i  (cfg_en_i),
  .q_o       (q_o),
  .reg_en_i  (reg_en),
  .sum_i     (sum),
  .and_conn_i(and_conn)
);

// File: tb/sop_logic_array_tb.sv
`timescale 1ns/1ps
module sop_logic_array_tb_top;
  localparam int NI = 4, NP = 8, NO = 4;
  localparam int AW = 2 * NI * NP;
  localparam int OW = NP * NO;
  localparam int LP = AW + OW + NO;
  localparam int LF = AW + NO;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_a = 1'b0, bit_a = 1'b0, en_f = 1'b0, bit_f = 1'b0;
  logic [NI-1:0] data = '0;
  logic [NO-1:0] q_a, q_f;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  sop_logic_array #(.N_IN(NI), .N_PT(NP), .N_OUT(NO), .FIXED_OR(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_en_i(en_a), .cfg_bit_i(bit_a),
    .data_i(data), .q_o(q_a));

  sop_logic_array #(.N_IN(NI), .N_PT(NP), .N_OUT(NO), .FIXED_OR(1'b1)) dut_pal_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_en_i(en_f), .cfg_bit_i(bit_f),
    .data_i(data), .q_o(q_f));

  function automatic logic [NO-1:0] model(input logic [NI-1:0] d, input logic [AW-1:0] a,
                                          input logic [OW-1:0] orv, input bit fixed);
    logic [NP-1:0] pt;
    logic [NO-1:0] s;
    for (int p = 0; p < NP; p++) begin
      logic any, ok;
      any = 1'b0; ok = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (a[p*2*NI+2*i])   begin any = 1'b1; if (!d[i]) ok = 1'b0; end
        if (a[p*2*NI+2*i+1]) begin any = 1'b1; if (d[i])  ok = 1'b0; end
      end
      pt[p] = any && ok;
    end
    for (int o = 0; o < NO; o++) begin
      s[o] = 1'b0;
      for (int p = 0; p < NP; p++)
        if (fixed ? (p / (NP / NO) == o) : orv[o*NP+p]) s[o] = s[o] | pt[p];
    end
    return s;
  endfunction

  task automatic check(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_a(input logic [AW-1:0] a, input logic [OW-1:0] orv, input logic [NO-1:0] rg);
    logic [LP-1:0] v;
    v = {a, orv, rg};
    en_a = 1'b1;
    for (int i = LP - 1; i >= 0; i--) begin
      bit_a = v[i];
      @(posedge clk); #1;
      if (i == LP / 2) check("R7 idle during load", q_a, '0);
    end
    en_a = 1'b0;
  endtask

  task automatic load_f(input logic [AW-1:0] a, input logic [NO-1:0] rg);
    logic [LF-1:0] v;
    v = {a, rg};
    en_f = 1'b1;
    for (int i = LF - 1; i >= 0; i--) begin
      bit_f = v[i];
      @(posedge clk); #1;
    end
    en_f = 1'b0;
  endtask

  // combinational sweep over all inputs
  task automatic sweep_a(input string req, input logic [AW-1:0] a, input logic [OW-1:0] orv);
    for (int v = 0; v < (1 << NI); v++) begin
      data = NI'(v); #3;
      check(req, q_a, model(NI'(v), a, orv, 1'b0));
      @(posedge clk); #1;
    end
  endtask

  // registered sweep: before the edge old value, after the edge new value
  task automatic sweep_reg(input string req, input bit fixed, input logic [AW-1:0] a,
                           input logic [OW-1:0] orv, input logic [NO-1:0] rg);
    logic [NO-1:0] prev, cur, exp;
    prev = '0;
    for (int v = 0; v < (1 << NI); v++) begin
      data = NI'(v); #3;
      cur = model(NI'(v), a, orv, fixed);
      exp = (prev & rg) | (cur & ~rg);
      check({req, " pre-edge"}, fixed ? q_f : q_a, exp);
      @(posedge clk); #1;
      check({req, " post-edge"}, fixed ? q_f : q_a, cur);
      prev = cur;
    end
  endtask

  logic [AW-1:0] ca;
  logic [OW-1:0] co;

  initial begin : wdog
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset out", q_a, '0);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    // R3: unprogrammed array
    sweep_a("R3 empty array", '0, '0);

    // hand config: p0=x0&~x1, p1=x2&x3, p2=x0&~x0, p3 empty, p4=~x3
    ca = '0; co = '0;
    ca[0*8+0] = 1'b1; ca[0*8+3] = 1'b1;
    ca[1*8+4] = 1'b1; ca[1*8+6] = 1'b1;
    ca[2*8+0] = 1'b1; ca[2*8+1] = 1'b1;
    ca[4*8+7] = 1'b1;
    co[0*8+0] = 1'b1; co[0*8+1] = 1'b1;        // R5 out0 = p0|p1
    co[1*8+1] = 1'b1; co[1*8+4] = 1'b1;        // out1 = p1|p4
    co[2*8+2] = 1'b1; co[2*8+4] = 1'b1;        // R4 out2 = contradiction|p4
    co[3*8+3] = 1'b1; co[3*8+1] = 1'b1;        // R3 out3 = empty|p1
    load_a(ca, co, '0);
    sweep_a("R1 R2 R4 R5 hand config", ca, co);
    // R4 alone on an output
    co = '0; co[2*8+2] = 1'b1; co[3*8+3] = 1'b1;
    load_a(ca, co, '0);
    sweep_a("R4 contradiction term", ca, co);

    // R6: bit input toggling while disabled has no effect
    for (int k = 0; k < 12; k++) begin
      bit_a = k[0]; @(posedge clk); #1;
    end
    sweep_a("R6 hold while disabled", ca, co);

    for (int r = 0; r < 6; r++) begin
      ca = {$urandom, $urandom} & {$urandom, $urandom};
      co = $urandom;
      load_a(ca, co, '0);
      sweep_a("R1 random config", ca, co);
    end

    // R7/R8 registered outputs
    ca = {$urandom, $urandom} & {$urandom, $urandom}; co = $urandom;
    load_a(ca, co, 4'hF);
    sweep_reg("R8 all registered", 1'b0, ca, co, 4'hF);
    load_a(ca, co, 4'b0101);
    sweep_reg("R8 mixed registered", 1'b0, ca, co, 4'b0101);

    // R9 fixed OR plane
    for (int r = 0; r < 3; r++) begin
      ca = {$urandom, $urandom} & {$urandom, $urandom};
      load_f(ca, '0);
      sweep_reg("R9 fixed OR comb", 1'b1, ca, '0, '0);
    end
    load_f(ca, 4'hF);
    sweep_reg("R9 fixed OR registered", 1'b1, ca, '0, 4'hF);

    // R10: async reset wipes configuration
    data = 4'h5; #1;
    rst_ni = 1'b0; #1;
    check("R10 async reset", q_a, '0);
    check("R10 async reset pal", q_f, '0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    @(posedge clk); #1;
    sweep_a("R10 config cleared", '0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule